// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block stores 9-bit words between two unrelated clock domains. A producer writes on its own clock, gated by two write enables. A consumer pulls words into a registered output on its own clock, gated by two read enables. The write pointer and the read pointer cross between the domains as Gray codes through two-flop synchronizers. The pointers carry one extra bit so that a full buffer can be told apart from an empty one. The depth is a power-of-two parameter and defaults to 256.

Four active-low status flags report the fill level:
- empty and almost-empty are produced in the read domain;
- full and almost-full are produced in the write domain.

The two almost thresholds come from offsets, n for almost-empty and m for almost-full. A companion register block supplies them on two plain inputs. The level of the `wen2_ld` pin while reset is held selects the operating mode:
- Pin high: the pin is a second write enable, and both offsets are fixed at 7.
- Pin low: programmable mode. The offsets come from the inputs. Driving the pin low together with write enable 1 turns that cycle into an offset-register access for the companion block, and no word is stored.

Flow control uses the flags, not a valid/ready handshake. A producer must treat `full_n` low as back-pressure, and a consumer must treat `empty_n` low as no data. Requests made against a low flag are dropped, not queued. The data output is presented with an enable signal in place of a three-state driver.

Top module: `dcfifo_prog`

## Requirements
- R1: A word on `din` is stored at a rising `wclk` edge when `wen1_n` is 0, `wen2_ld` is 1 and `full_n` is 1. Words are read back in the order they were written.
- R2: At a rising `rclk` edge, the head word moves into the output register only when `ren1_n` and `ren2_n` are both 0 and `empty_n` is 1. Otherwise the output register keeps its value.
- R3: A write request while `full_n` is 0 changes nothing. A read request while `empty_n` is 0 changes nothing.
- R4: Once the pointers have settled, `empty_n` is 0 exactly when 0 words are stored, and `full_n` is 0 exactly when DEPTH words are stored.
- R5: While `rst_n` is 0, both pointers return to location 0. `full_n` and `af_n` go to 1, `empty_n` and `ae_n` go to 0, and the output register is cleared to zero.
- R6: The level of `wen2_ld` during reset selects the mode, and the mode stays fixed until the next reset.
  - Level 1 selects dual-enable mode, with both offsets fixed at 7.
  - Level 0 selects programmable mode, with n taken from `ae_ofs` and m from `af_ofs`.
  - In programmable mode, `wen1_n`=0 together with `wen2_ld`=0 raises `ofs_load` and stores no word.
  - In dual-enable mode, `ofs_load` stays 0.
- R7: Once settled, `ae_n` is 0 for a fill count from 0 to n and 1 from n+1 upward.
- R8: Once settled, `af_n` is 0 when the fill count is at least DEPTH-m and 1 below that.
- R9: When `oe_n` is 1, `dout` is all zero and `dout_en` is 0. When `oe_n` is 0, `dout_en` is 1 and `dout` shows the output register.
- R10: A word written into an empty buffer makes `empty_n` rise within 4 read-clock edges after the writing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset of both domains |
| wen1_n | input | 1 | Write enable 1, active low |
| wen2_ld | input | 1 | Write enable 2 (active high) or offset-load control (active low); acts as mode strap during reset |
| din | input | DW (9) | Write data |
| ae_ofs | input | AW (8) | Almost-empty offset n, used in programmable mode |
| af_ofs | input | AW (8) | Almost-full offset m, used in programmable mode |
| ofs_load | output | 1 | Offset-register access strobe for the companion block |
| full_n | output | 1 | Full flag, active low, write domain |
| af_n | output | 1 | Almost-full flag, active low, write domain |
| ren1_n | input | 1 | Read enable 1, active low |
| ren2_n | input | 1 | Read enable 2, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | DW (9) | Output register contents, zero while disabled |
| dout_en | output | 1 | High when `dout` is driven |
| empty_n | output | 1 | Empty flag, active low, read domain |
| ae_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
The assertions assume the following about the inputs:
- The `wen2_ld` strap holds its level from the start of reset until both synchronized resets have released.
- The offset inputs are quasi-static while words are moving.
- `rst_n` is low at time zero.

Under these conditions the flags are pessimistic but never wrong: an asserted `empty_n`, `full_n` or `ae_n` always matches the true pointer distance. The stimulus keeps within these assumptions:
- It changes the strap and the offsets only inside a reset window that spans several edges of both clocks.
- It checks each flag only after both domains have idled long enough for the synchronizers to settle.

This lets the bench compute every expected flag level directly from the word count it tracks.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic {
    MODE_DUAL_WE   = 1'b0,
    MODE_PROG_FLAG = 1'b1
  } fifo_mode_e;

  localparam int unsigned DEF_OFFSET = 7;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= d;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

module dcf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int unsigned DW    = 9,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [AW-1:0] af_ofs,
  input  logic [PW-1:0] rgray_sync,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full_n,
  output logic          af_n,
  output logic          ofs_load
);
  fifo_mode_e    mode_q;
  logic [PW-1:0] wbin_q, wbin_nx, rbin_s;
  logic [PW-1:0] cnt_nx, cnt_now, af_thr;
  logic [AW-1:0] m_ofs;
  logic          wr_try;

  // Mode strap: sampled on every edge while the synchronized reset is low.
  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      mode_q <= wen2_ld ? MODE_DUAL_WE : MODE_PROG_FLAG;
    end
  end

  assign wr_try   = !wen1_n && wen2_ld;
  assign we       = wr_try && full_n;
  assign ofs_load = (mode_q == MODE_PROG_FLAG) && !wen2_ld && !wen1_n;

  assign rbin_s  = PW'(gray2bin(32'(rgray_sync)));
  assign wbin_nx = wbin_q + PW'(we);
  assign m_ofs   = (mode_q == MODE_PROG_FLAG) ? af_ofs : AW'(DEF_OFFSET);
  assign af_thr  = PW'(DEPTH) - PW'(m_ofs);
  assign cnt_nx  = wbin_nx - rbin_s;
  assign cnt_now = wbin_q - rbin_s;
  assign waddr   = wbin_q[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q <= '0;
      wgray  <= '0;
      full_n <= 1'b1;
      af_n   <= 1'b1;
    end else begin
      wbin_q <= wbin_nx;
      wgray  <= PW'(bin2gray(32'(wbin_nx)));
      full_n <= (cnt_nx != PW'(DEPTH));
      af_n   <= (cnt_nx < af_thr);
    end
  end

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n) |=> $stable(wbin_q));

  p_ofs_no_store_r6: assert property (@(posedge wclk) disable iff (!rst_n)
    ofs_load |=> $stable(wbin_q));

  p_mode_hold_r6: assert property (@(posedge wclk) disable iff (!rst_n)
    $stable(mode_q));

  p_count_bound_r4: assert property (@(posedge wclk) disable iff (!rst_n)
    cnt_now <= PW'(DEPTH));

  p_full_safe_r4: assert property (@(posedge wclk) disable iff (!rst_n)
    full_n |-> (cnt_now != PW'(DEPTH)));

  p_dual_no_load_r6: assert property (@(posedge wclk) disable iff (!rst_n)
    (mode_q == MODE_DUAL_WE) |-> !ofs_load);
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int unsigned DW    = 9,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          strap,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic [AW-1:0] ae_ofs,
  input  logic [PW-1:0] wgray_sync,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [DW-1:0] q,
  output logic          empty_n,
  output logic          ae_n
);
  fifo_mode_e    mode_q;
  logic [PW-1:0] rbin_q, rbin_nx, wbin_s;
  logic [PW-1:0] cnt_nx, cnt_now;
  logic [AW-1:0] n_ofs;
  logic          rd_fire;

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      mode_q <= strap ? MODE_DUAL_WE : MODE_PROG_FLAG;
    end
  end

  assign rd_fire = !ren1_n && !ren2_n && empty_n;
  assign wbin_s  = PW'(gray2bin(32'(wgray_sync)));
  assign rbin_nx = rbin_q + PW'(rd_fire);
  assign n_ofs   = (mode_q == MODE_PROG_FLAG) ? ae_ofs : AW'(DEF_OFFSET);
  assign cnt_nx  = wbin_s - rbin_nx;
  assign cnt_now = wbin_s - rbin_q;
  assign raddr   = rbin_q[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray   <= '0;
      q       <= '0;
      empty_n <= 1'b0;
      ae_n    <= 1'b0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray   <= PW'(bin2gray(32'(rbin_nx)));
      empty_n <= (cnt_nx != '0);
      ae_n    <= (cnt_nx > PW'(n_ofs));
      if (rd_fire) begin
        q <= rdata;
      end
    end
  end

  p_no_underflow_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n) |=> $stable(rbin_q));

  p_hold_q_r2: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_fire) |=> $stable(q));

  p_empty_safe_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    empty_n |-> (cnt_now != '0));

  p_ae_safe_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    ae_n |-> (cnt_now > PW'(n_ofs)));

  p_rd_mode_hold_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    $stable(mode_q));
endmodule

// File: rtl/dcfifo_prog.sv
module dcfifo_prog #(
  parameter int unsigned DW    = 9,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] ae_ofs,
  input  logic [AW-1:0] af_ofs,
  output logic          ofs_load,
  output logic          full_n,
  output logic          af_n,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          empty_n,
  output logic          ae_n
);
  logic          rst_n_w, rst_n_r;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_sync, rgray_sync;
  logic [DW-1:0] rdata, q;

  dcf_rst_sync #(.STAGES(2)) u_rst_w (.clk(wclk), .arst_n(rst_n), .rst_n_o(rst_n_w));
  dcf_rst_sync #(.STAGES(2)) u_rst_r (.clk(rclk), .arst_n(rst_n), .rst_n_o(rst_n_r));

  dcf_sync #(.W(PW), .STAGES(2)) u_sync_r2w (
    .clk(wclk), .rst_n(rst_n_w), .d(rgray), .q(rgray_sync));
  dcf_sync #(.W(PW), .STAGES(2)) u_sync_w2r (
    .clk(rclk), .rst_n(rst_n_r), .d(wgray), .q(wgray_sync));

  dcf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
    .raddr(raddr), .rdata(rdata));

  dcf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .rst_n(rst_n_w), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .af_ofs(af_ofs), .rgray_sync(rgray_sync), .we(we), .waddr(waddr),
    .wgray(wgray), .full_n(full_n), .af_n(af_n), .ofs_load(ofs_load));

  dcf_rd_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rst_n(rst_n_r), .strap(wen2_ld), .ren1_n(ren1_n),
    .ren2_n(ren2_n), .ae_ofs(ae_ofs), .wgray_sync(wgray_sync),
    .rdata(rdata), .raddr(raddr), .rgray(rgray), .q(q),
    .empty_n(empty_n), .ae_n(ae_n));

  assign dout_en = !oe_n;
  assign dout    = oe_n ? '0 : q;

  p_dout_steady_r2: assert property (@(posedge rclk) disable iff (!rst_n_r)
    (!oe_n && !(!ren1_n && !ren2_n && empty_n)) |=> (oe_n || $stable(dout)));

  p_flags_disjoint_r4: assert property (@(posedge rclk) disable iff (!rst_n_r)
    ae_n |-> empty_n);

  p_wflags_order_r8: assert property (@(posedge wclk) disable iff (!rst_n_w)
    af_n |-> full_n);
endmodule

// File: tb/dcfifo_prog_tb_top.sv
module dcfifo_prog_tb_top;
  localparam int unsigned DW    = 9;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW    = 4;

  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n = 1'b0;
  logic wen1_n = 1'b1, wen2_ld = 1'b1;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] ae_ofs = '0, af_ofs = '0;
  logic ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
  logic ofs_load, full_n, af_n, dout_en, empty_n, ae_n;
  logic [DW-1:0] dout;

  int compared = 0, mismatched = 0;
  logic [DW-1:0] model_q [$];
  logic [DW-1:0] last_q = '0;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dcfifo_prog #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n),
    .wen2_ld(wen2_ld), .din(din), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .ofs_load(ofs_load), .full_n(full_n), .af_n(af_n), .ren1_n(ren1_n),
    .ren2_n(ren2_n), .oe_n(oe_n), .dout(dout), .dout_en(dout_en),
    .empty_n(empty_n), .ae_n(ae_n));

  task automatic chk(input string tag, input int act, input int expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (8) @(posedge wclk);
    @(negedge rclk);
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    wen2_ld = strap;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge wclk); rst_n = 1'b1;
    repeat (6) @(posedge wclk);
    repeat (6) @(posedge rclk);
    @(negedge wclk); wen2_ld = 1'b1;
    model_q.delete();
    last_q = '0;
    settle();
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wclk); din = d; wen1_n = 1'b0;
    @(negedge wclk); wen1_n = 1'b1;
    if (model_q.size() < DEPTH) model_q.push_back(d);
  endtask

  task automatic rd_word(input string tag);
    @(negedge rclk); ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge rclk); ren1_n = 1'b1; ren2_n = 1'b1;
    if (model_q.size() > 0) last_q = model_q.pop_front();
    chk(tag, int'(dout), int'(last_q));
  endtask

  task automatic check_flags(input int n, input int m, input string ph);
    int c;
    c = model_q.size();
    chk($sformatf("R4 empty_n %s cnt=%0d", ph, c), int'(empty_n), (c != 0) ? 1 : 0);
    chk($sformatf("R4 full_n %s cnt=%0d", ph, c), int'(full_n), (c != DEPTH) ? 1 : 0);
    chk($sformatf("R7 ae_n %s cnt=%0d", ph, c), int'(ae_n), (c > n) ? 1 : 0);
    chk($sformatf("R8 af_n %s cnt=%0d", ph, c), int'(af_n), (c < DEPTH - m) ? 1 : 0);
  endtask

  task automatic check_reset(input string ph);
    chk({"R5 full_n ", ph}, int'(full_n), 1);
    chk({"R5 af_n ", ph}, int'(af_n), 1);
    chk({"R5 empty_n ", ph}, int'(empty_n), 0);
    chk({"R5 ae_n ", ph}, int'(ae_n), 0);
    chk({"R5 dout zero ", ph}, int'(dout), 0);
  endtask

  task automatic fill_drain(input int n, input int m, input string ph);
    for (int k = 0; k < DEPTH; k++) begin
      wr_word(DW'(k * 37 + 5 + n));
      settle();
      check_flags(n, m, ph);
    end
    wr_word(9'h1AA);
    wr_word(9'h155);
    settle();
    check_flags(n, m, {ph, " R3 write at full"});
    for (int k = 0; k < DEPTH; k++) begin
      if (k == 3) begin
        @(negedge rclk); ren1_n = 1'b0; ren2_n = 1'b1;
        @(negedge rclk); ren1_n = 1'b1;
        chk({"R2 one enable holds ", ph}, int'(dout), int'(last_q));
      end
      rd_word({"R1 order ", ph});
      settle();
      check_flags(n, m, ph);
    end
    rd_word({"R3 read at empty holds ", ph});
    settle();
    check_flags(n, m, {ph, " R3 after empty read"});
  endtask

  initial begin
    int lat;
    do_reset(1'b1);
    check_reset("dual");

    // R10 latency from the empty boundary
    @(negedge wclk); din = 9'h0C3; wen1_n = 1'b0;
    @(posedge wclk); #0.5 wen1_n = 1'b1;
    model_q.push_back(9'h0C3);
    lat = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge rclk);
      lat++;
      if (empty_n) break;
    end
    chk("R10 empty_n rise within 4", (lat <= 4) ? 1 : 0, 1);
    settle();
    rd_word("R1 first word");
    settle();

    // R1: in dual mode, enable 2 low blocks the write and raises no load strobe
    @(negedge wclk); wen1_n = 1'b0; wen2_ld = 1'b0;
    #0.5 chk("R6 dual ofs_load low", int'(ofs_load), 0);
    @(negedge wclk); wen1_n = 1'b1; wen2_ld = 1'b1;
    settle();
    check_flags(7, 7, "R1 wen2 low");

    fill_drain(7, 7, "dual");

    // R9 output enable
    oe_n = 1'b1; #0.5;
    chk("R9 dout zero when disabled", int'(dout), 0);
    chk("R9 dout_en low", int'(dout_en), 0);
    oe_n = 1'b0; #0.5;
    chk("R9 dout shows register", int'(dout), int'(last_q));
    chk("R9 dout_en high", int'(dout_en), 1);

    // Programmable mode
    ae_ofs = 4'd3; af_ofs = 4'd5;
    do_reset(1'b0);
    check_reset("prog");
    @(negedge wclk); din = 9'h111; wen2_ld = 1'b0; wen1_n = 1'b0;
    #0.5 chk("R6 ofs_load strobe", int'(ofs_load), 1);
    @(negedge wclk); wen1_n = 1'b1; wen2_ld = 1'b1;
    #0.5 chk("R6 ofs_load released", int'(ofs_load), 0);
    settle();
    check_flags(3, 5, "R6 load stores nothing");
    fill_drain(3, 5, "prog");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule